// File: doc/BRIEF.md
# Two-Byte Accumulator Processor Core

A compact multicycle processor with an 8-bit accumulator A, an 8-bit pointer register B, an 8-bit program counter and a single zero flag. One byte-wide synchronous memory port carries both instruction fetches and data traffic. Read data returns on the clock after the read strobe. Every instruction takes two bytes: an opcode followed by an operand, which holds a direct address or an immediate constant.

An instruction runs through a fixed sequence. The opcode is fetched, then the operand is fetched, then the operand is latched. An execute cycle follows, and instructions that read memory add one more cycle to absorb the data. Operands can be direct addresses, the address held in B, or constants carried in the instruction. A conditional jump and a halt complete the set. The core is used by placing a program in the attached memory and releasing reset. It then runs until it reaches a halt or an undefined opcode.

Top module: `acc_core`

## Requirements
- R1: Reset clears A, B, the program counter and the zero flag to 0. The first access after reset is a read at address 0x00, and `halted` and `illegal` are both low.
- R2: The opcode byte is read at PC and the operand byte at PC+1. After any instruction other than a jump, PC advances by 2 modulo 256, so an instruction at 0xFE is followed by one at 0x00.
- R3: Direct-address opcodes: 0x00 loads A from mem[op], 0x01 stores A to mem[op], 0x02 adds mem[op] to A, 0x03 subtracts mem[op] from A, and 0x06 loads B from mem[op].
- R4: Opcode 0x07 loads A from mem[B] and opcode 0x0A stores A to mem[B]. Their operand byte is fetched and has no effect.
- R5: Immediate opcodes: 0x08 adds the operand to A, 0x09 adds the operand to B, and 0x0B subtracts the operand from A. All arithmetic wraps modulo 256.
- R6: Opcodes 0x02, 0x03, 0x08 and 0x0B set the zero flag to (result == 0). All other opcodes leave the zero flag unchanged.
- R7: Opcode 0x04 loads the operand into PC when the zero flag is 0. When the zero flag is 1, it advances PC by 2.
- R8: Opcode 0x05 raises `halted`. From then until reset, the core asserts neither `mem_rd` nor `mem_wr`.
- R9: Opcodes 0x0C to 0xFF act as halt and also raise `illegal`. The instruction that follows in memory is not executed.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Memory address for a fetch, read or write |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one clock later |
| mem_wr | output | 1 | Write strobe; `mem_wdata` is written to `mem_addr` at the clock edge |
| mem_wdata | output | 8 | Write data, always the accumulator |
| mem_rdata | input | 8 | Read data from the synchronous memory |
| halted | output | 1 | High once a halt or an undefined opcode has executed |
| illegal | output | 1 | High once an undefined opcode has executed |

## Verification
Every store shows up at the port as an address and data pair. A corrupted accumulator, pointer or flag therefore appears at the next store that depends on it. A wrong flag appears as a store that is skipped or added after the next conditional jump. A program counter error redirects the following fetch, which exposes it within about four cycles, usually as a wrong or missing write. The test programs are built so that each register's value is committed to memory soon after it changes. Wrong halting behaviour is caught by watching the bus go quiet and stay quiet.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         halted,
  output logic         illegal
);
  localparam logic [W-1:0] OP_LDA  = W'(8'h00);
  localparam logic [W-1:0] OP_STA  = W'(8'h01);
  localparam logic [W-1:0] OP_ADD  = W'(8'h02);
  localparam logic [W-1:0] OP_SUB  = W'(8'h03);
  localparam logic [W-1:0] OP_JNZ  = W'(8'h04);
  localparam logic [W-1:0] OP_HLT  = W'(8'h05);
  localparam logic [W-1:0] OP_LDB  = W'(8'h06);
  localparam logic [W-1:0] OP_LDAI = W'(8'h07);
  localparam logic [W-1:0] OP_ADDK = W'(8'h08);
  localparam logic [W-1:0] OP_ADBK = W'(8'h09);
  localparam logic [W-1:0] OP_STAI = W'(8'h0A);
  localparam logic [W-1:0] OP_SUBK = W'(8'h0B);
  localparam logic [W-1:0] STEP    = W'(2);

  typedef enum logic [2:0] {S_OP, S_ARG, S_DEC, S_EXE, S_MEM, S_HLT} st_t;

  st_t         st;
  logic [W-1:0] a_q, b_q, pc_q, op_q, arg_q;
  logic         z_q, ill_q;

  wire via_b  = (op_q == OP_LDAI) || (op_q == OP_STAI);
  wire needs_rd = (op_q == OP_LDA) || (op_q == OP_ADD) || (op_q == OP_SUB) ||
                  (op_q == OP_LDB) || (op_q == OP_LDAI);
  wire needs_wr = (op_q == OP_STA) || (op_q == OP_STAI);

  wire [W-1:0] opnd = (st == S_MEM) ? mem_rdata : arg_q;
  wire [W-1:0] sum  = a_q + opnd;
  wire [W-1:0] diff = a_q - opnd;
  wire [W-1:0] pc_next = pc_q + STEP;

  assign mem_rd    = (st == S_OP) || (st == S_ARG) || (st == S_EXE && needs_rd);
  assign mem_wr    = (st == S_EXE) && needs_wr;
  assign mem_addr  = (st == S_OP)  ? pc_q :
                     (st == S_ARG) ? pc_q + W'(1) :
                     via_b         ? b_q : arg_q;
  assign mem_wdata = a_q;
  assign halted    = (st == S_HLT);
  assign illegal   = ill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_OP;
      a_q   <= '0;
      b_q   <= '0;
      pc_q  <= '0;
      op_q  <= '0;
      arg_q <= '0;
      z_q   <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      case (st)
        S_OP:  st <= S_ARG;
        S_ARG: begin
          op_q <= mem_rdata;
          st   <= S_DEC;
        end
        S_DEC: begin
          arg_q <= mem_rdata;
          st    <= S_EXE;
        end
        S_EXE: begin
          st <= S_OP;
          case (op_q)
            OP_LDA, OP_ADD, OP_SUB, OP_LDB, OP_LDAI: st <= S_MEM;
            OP_STA, OP_STAI: pc_q <= pc_next;
            OP_ADDK: begin
              a_q  <= sum;
              z_q  <= (sum == '0);
              pc_q <= pc_next;
            end
            OP_SUBK: begin
              a_q  <= diff;
              z_q  <= (diff == '0);
              pc_q <= pc_next;
            end
            OP_ADBK: begin
              b_q  <= b_q + arg_q;
              pc_q <= pc_next;
            end
            OP_JNZ:  pc_q <= z_q ? pc_next : arg_q;
            OP_HLT:  st <= S_HLT;
            default: begin
              st    <= S_HLT;
              ill_q <= 1'b1;
            end
          endcase
        end
        S_MEM: begin
          case (op_q)
            OP_ADD: begin
              a_q <= sum;
              z_q <= (sum == '0);
            end
            OP_SUB: begin
              a_q <= diff;
              z_q <= (diff == '0);
            end
            OP_LDB:  b_q <= mem_rdata;
            default: a_q <= mem_rdata;
          endcase
          pc_q <= pc_next;
          st   <= S_OP;
        end
        default: st <= S_HLT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] mem_addr,
  input logic         mem_rd,
  input logic         mem_wr,
  input logic         halted,
  input logic         illegal
);
  assert_no_rdwr_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  assert_illegal_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);

  assert_store_then_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (mem_rd && !halted));

  assert_addr_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !$isunknown(mem_addr));
endmodule

bind acc_core acc_core_chk #(.W(W)) u_chk (.*);

// File: tb/tb_acc_core.sv
module tb_acc_core;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_rd, mem_wr, halted, illegal;

  logic [7:0] mem [256];
  logic       clr = 1'b0, ld_en = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;

  int checks = 0, fails = 0;
  logic [15:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .illegal(illegal)
  );

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected stores as the core writes
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (expq.size() == 0) check(1'b0, "R3/R4 unexpected store", {mem_addr, mem_wdata}, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        check({mem_addr, mem_wdata} == e, "R3/R4/R5/R6/R7 store", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic exp_wr(input logic [7:0] a, input logic [7:0] d);
    expq.push_back({a, d});
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
  endtask

  task automatic ins(input logic [7:0] a, input logic [7:0] op, input logic [7:0] arg);
    poke(a, op);
    poke(a + 8'd1, arg);
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    expq.delete();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run_prog(input string name, input bit exp_ill);
    int n;
    int busy;
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(mem_rd && !mem_wr && mem_addr == 8'h00, "R1 first fetch at 0", mem_addr, 0);
    check(!halted && !illegal, "R1 status low after reset", {halted, illegal}, 0);
    n = 0;
    while (!halted && n < RUN_LIMIT) begin
      @(negedge clk);
      n++;
    end
    check(n < RUN_LIMIT, "watchdog", n, RUN_LIMIT);
    check(expq.size() == 0, "R3/R7 all stores seen", expq.size(), 0);
    check(illegal == exp_ill, exp_ill ? "R9 illegal flag" : "R8 illegal low", illegal, exp_ill);
    busy = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted) busy++;
    end
    check(busy == 0, "R8 quiet after halt", busy, 0);
    $display("program %s done", name);
  endtask

  initial begin
    // Program 1: increment a table through B (R3 R4 R5 R6 R7 R2)
    begin_prog();
    ins(8'h00, 8'h00, 8'h30);
    ins(8'h02, 8'h01, 8'h31);
    ins(8'h04, 8'h06, 8'h32);
    ins(8'h06, 8'h07, 8'h99);  // R4 operand ignored
    ins(8'h08, 8'h08, 8'h01);
    ins(8'h0A, 8'h0A, 8'h77);  // R4 operand ignored
    ins(8'h0C, 8'h09, 8'h01);
    ins(8'h0E, 8'h00, 8'h31);
    ins(8'h10, 8'h0B, 8'h01);
    ins(8'h12, 8'h01, 8'h31);
    ins(8'h14, 8'h04, 8'h06);
    ins(8'h16, 8'h05, 8'h00);
    poke(8'h30, 8'h03); poke(8'h32, 8'h40);
    poke(8'h40, 8'h10); poke(8'h41, 8'hFF); poke(8'h42, 8'h7F);
    exp_wr(8'h31, 8'h03);
    exp_wr(8'h40, 8'h11); exp_wr(8'h31, 8'h02);
    exp_wr(8'h41, 8'h00); exp_wr(8'h31, 8'h01);
    exp_wr(8'h42, 8'h80); exp_wr(8'h31, 8'h00);
    run_prog("table", 1'b0);

    // Program 2: reset values of A and B, then an undefined opcode (R1 R9)
    begin_prog();
    ins(8'h00, 8'h08, 8'h2C);
    ins(8'h02, 8'h01, 8'h40);
    ins(8'h04, 8'h0A, 8'h55);
    ins(8'h06, 8'h0C, 8'h00);
    ins(8'h08, 8'h01, 8'h41);
    exp_wr(8'h40, 8'h2C);   // R1 A started at 0
    exp_wr(8'h00, 8'h2C);   // R1 B started at 0
    run_prog("illegal", 1'b1);

    // Program 3: PC wrap, flag retention, jump not taken (R2 R6 R7 R1)
    begin_prog();
    ins(8'h00, 8'h04, 8'hF0);  // R1 Z=0 after reset -> taken
    ins(8'h02, 8'h01, 8'h51);
    ins(8'h04, 8'h05, 8'h00);
    ins(8'hF0, 8'h00, 8'h60);
    ins(8'hF2, 8'h01, 8'h50);
    ins(8'hF4, 8'h03, 8'h60);
    ins(8'hF6, 8'h08, 8'h09);
    ins(8'hF8, 8'h0B, 8'h09);
    ins(8'hFA, 8'h06, 8'h61);  // R6 load B keeps Z=1
    ins(8'hFC, 8'h0A, 8'h00);
    ins(8'hFE, 8'h08, 8'h00);  // R2 wraps to 0x00
    poke(8'h60, 8'h03); poke(8'h61, 8'h77);
    exp_wr(8'h50, 8'h03);
    exp_wr(8'h77, 8'h00);
    exp_wr(8'h51, 8'h00);      // R7 not taken with Z=1
    run_prog("wrap", 1'b0);

    // Program 4: direct add clears Z so jump is taken; halt at once (R6 R7 R8)
    begin_prog();
    ins(8'h00, 8'h0B, 8'h01);  // A=FF Z=0
    ins(8'h02, 8'h02, 8'h20);  // A=FF+01=00 Z=1
    ins(8'h04, 8'h04, 8'h10);  // not taken
    ins(8'h06, 8'h02, 8'h21);  // A=05 Z=0
    ins(8'h08, 8'h09, 8'h00);  // R6 B op keeps Z=0
    ins(8'h0A, 8'h04, 8'h10);  // taken
    ins(8'h0C, 8'h01, 8'h70);
    ins(8'h10, 8'h01, 8'h71);
    ins(8'h12, 8'h05, 8'h00);
    ins(8'h14, 8'h01, 8'h72);
    poke(8'h20, 8'h01); poke(8'h21, 8'h05);
    exp_wr(8'h71, 8'h05);
    run_prog("branch", 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule